// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the 256-byte type-0 configuration header of a PCI target bridge. It contains the fixed identification fields, the command and status registers, an I/O and a memory base address register, the interrupt line and pin bytes, the control registers for a set of slave address windows, and an interrupt enable and level register. The bus interface logic does not belong to this block. It reaches the registers through a plain word port made of an address, four byte enables, write data, a write strobe and combinational read data.

Two access paths lead to the same storage. A configuration access (`acc_is_cfg` high) uses address bits 7..0 as the header offset. A device-space access (`acc_is_cfg` low) hits the header only inside a 256-byte alias window that starts at `ALIAS_BASE` (0xF800 by default), so that CSR-space address 0xF800 + n reaches header offset n. A device-space access outside that window reads zero and writes nothing. The block drives its enable bits, base addresses and window values straight out to the surrounding logic. It also drives a level interrupt request, formed from the software enable and the live priority input.

Top module: `cfgspace_regfile`

## Requirements
- R1: Offset 0x00 reads 0x48001057 (device 0x4800 in the upper half, vendor 0x1057 in the lower). Offset 0x08 reads 0x06800001 (class code 0x068000 above revision 0x01). Byte 1 of offset 0x3C (the interrupt pin) reads 0x01. None of these change on writes.
- R2: Offset 0x0C (cache line, latency timer, header type, BIST) reads 0, and so do bytes 2 and 3 of offset 0x3C (minimum grant, maximum latency). Writes to them have no effect.
- R3: Command bits 0 (I/O space enable), 1 (memory space enable) and 2 (bus master enable) sit at offset 0x04. They are read/write, reset to 0, and drive `io_space_en`, `mem_space_en` and `bus_master_en`.
- R4: In the status half of offset 0x04, bit 23 (fast back-to-back) reads 0 and bits 26..25 (select timing) read binary 01. Bits 27, 28 and 29 (signaled target abort, received target abort, received master abort) are set by the pulses `evt_sig_tabort`, `evt_rcv_tabort` and `evt_rcv_mabort`. Writing 1 to one of these bits clears it, writing 0 leaves it alone, and an event in the same cycle as a clear wins.
- R5: Offset 0x10 resets to 0x00000001. Only bits 31..16 are writable, and they drive `io_base`. Bit 0 always reads 1 and bits 15..1 always read 0.
- R6: Offset 0x14 resets to 0. Only bits 31..16 are writable, and they drive `mem_base`. Bits 15..0 always read 0.
- R7: Byte 0 of offset 0x3C (the interrupt line) is read/write and resets to 0.
- R8: Window n (n = 0, 1) keeps its start in bits 15..0 and its end in bits 31..16 of offset 0x40 + 8n. It keeps its address offset in bits 15..0 and its enable in bit 16 of offset 0x44 + 8n. Bits 23..17 and 31..24 of that word read 0. All window fields reset to 0, and they drive `win_start`, `win_end`, `win_offset` and `win_en`, with window n at slice n.
- R9: Offset 0x50 holds a read/write enable at bit 3 and reads `irq_level` live at bits 2..0. `irq_req` is high exactly when the enable is set and `irq_level` is nonzero.
- R10: Every header offset not listed above reads 0, and writes to it change nothing.
- R11: With `acc_is_cfg` low, address 0xF800 + n reads and writes header offset n. Any address outside 0xF800..0xF8FF reads 0 and writes nothing.
- R12: Byte enable k qualifies bits 8k+7..8k of a write. Bytes that are not enabled keep their value, and this includes the clear-on-one status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_is_cfg | input | 1 | 1: configuration access, 0: device-space access |
| acc_addr | input | ADDR_W (16) | Byte address; bits 1..0 are ignored |
| acc_be | input | 4 | Byte enables for writes |
| acc_wdata | input | 32 | Write data |
| acc_we | input | 1 | Write strobe, one word per cycle |
| acc_rdata | output | 32 | Combinational read data for the addressed word |
| evt_sig_tabort | input | 1 | Pulse: target abort signaled as target |
| evt_rcv_tabort | input | 1 | Pulse: target abort received as master |
| evt_rcv_mabort | input | 1 | Pulse: master abort as master |
| irq_level | input | 3 | Live pending interrupt priority |
| io_space_en | output | 1 | Command I/O space enable |
| mem_space_en | output | 1 | Command memory space enable |
| bus_master_en | output | 1 | Command bus master enable |
| io_base | output | 16 | I/O base address bits 31..16 |
| mem_base | output | 16 | Memory base address bits 31..16 |
| win_en | output | NUM_WIN | Window enables |
| win_start | output | 16*NUM_WIN | Window start addresses, upper 16 bits |
| win_end | output | 16*NUM_WIN | Window end addresses, upper 16 bits |
| win_offset | output | 16*NUM_WIN | Window translation offsets |
| irq_req | output | 1 | Interrupt request to the bus |

## Verification
A corrupted stored field appears on `acc_rdata` as soon as the word is addressed, because the read path is combinational. It also appears on the matching control output in the cycle after the faulty write. The bench reads back every word right after writing it, so a wrong byte lane or a wrong mask shows up within one cycle. A broken alias decode shows up when a write made through one path is read back through the other. A lost or sticky abort flag shows up on the first status read after its event or its clear. A wrong interrupt gate shows up on `irq_req` in the same cycle that `irq_level` changes.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam logic [15:0] ID_VENDOR = 16'h1057;
    localparam logic [15:0] ID_DEVICE = 16'h4800;
    localparam logic [7:0]  ID_REV    = 8'h01;
    localparam logic [23:0] ID_CLASS  = 24'h068000;
    localparam logic [7:0]  ID_IPIN   = 8'h01;

    localparam int WORD_W = 6;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_IDENT  = 6'h00;
    localparam logic [WORD_W-1:0] W_CMDSTA = 6'h01;
    localparam logic [WORD_W-1:0] W_CLASS  = 6'h02;
    localparam logic [WORD_W-1:0] W_IOBAR  = 6'h04;
    localparam logic [WORD_W-1:0] W_MEMBAR = 6'h05;
    localparam logic [WORD_W-1:0] W_INTLN  = 6'h0F;
    localparam logic [WORD_W-1:0] W_WIN0   = 6'h10;
    localparam logic [WORD_W-1:0] W_ICTL   = 6'h14;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_CFG   = 2'd1,
        ACC_ALIAS = 2'd2
    } acc_kind_e;

    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgspace_decode.sv
module cfgspace_decode
    import cfgspace_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'hF800
) (
    input  logic                acc_is_cfg,
    input  logic [ADDR_W-1:0]   acc_addr,
    output acc_kind_e           kind,
    output logic [WORD_W-1:0]   word_idx
);

    logic unused_lsb;
    assign unused_lsb = ^acc_addr[1:0];

    always_comb begin
        if (acc_is_cfg) begin
            kind = ACC_CFG;
        end else if (acc_addr[ADDR_W-1:8] == ALIAS_BASE[ADDR_W-1:8]) begin
            kind = ACC_ALIAS;
        end else begin
            kind = ACC_NONE;
        end
        word_idx = acc_addr[7:2];
    end

endmodule

// File: rtl/cfgspace_w1c.sv
module cfgspace_w1c #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set_evt;
        end
    end

endmodule

// File: rtl/cfgspace_window.sv
module cfgspace_window
    import cfgspace_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_range,
    input  logic        we_ctrl,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [15:0] start_q,
    output logic [15:0] end_q,
    output logic [15:0] offset_q,
    output logic        en_q
);

    logic [31:0] range_nxt;
    logic [31:0] ctrl_nxt;

    always_comb begin
        range_nxt = be_merge({end_q, start_q}, wdata, be);
        ctrl_nxt  = be_merge({15'h0, en_q, offset_q}, wdata, be);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            end_q    <= '0;
            offset_q <= '0;
            en_q     <= 1'b0;
        end else begin
            if (we_range) begin
                start_q <= range_nxt[15:0];
                end_q   <= range_nxt[31:16];
            end
            if (we_ctrl) begin
                offset_q <= ctrl_nxt[15:0];
                en_q     <= ctrl_nxt[16];
            end
        end
    end

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
    import cfgspace_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'hF800,
    parameter int                NUM_WIN    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_is_cfg,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [3:0]             acc_be,
    input  logic [31:0]            acc_wdata,
    input  logic                   acc_we,
    output logic [31:0]            acc_rdata,
    input  logic                   evt_sig_tabort,
    input  logic                   evt_rcv_tabort,
    input  logic                   evt_rcv_mabort,
    input  logic [2:0]             irq_level,
    output logic                   io_space_en,
    output logic                   mem_space_en,
    output logic                   bus_master_en,
    output logic [15:0]            io_base,
    output logic [15:0]            mem_base,
    output logic [NUM_WIN-1:0]     win_en,
    output logic [16*NUM_WIN-1:0]  win_start,
    output logic [16*NUM_WIN-1:0]  win_end,
    output logic [16*NUM_WIN-1:0]  win_offset,
    output logic                   irq_req
);

    localparam int NFLAG = 3;

    acc_kind_e         acc_kind;
    logic [WORD_W-1:0] word_idx;
    logic              hit;
    logic              wr_hit;

    logic [2:0]        cmd_q;
    logic [15:0]       iobase_q;
    logic [15:0]       membase_q;
    logic [7:0]        iline_q;
    logic              ien_q;
    logic [NFLAG-1:0]  flag_q;
    logic [NFLAG-1:0]  flag_clr;
    logic [31:0]       wr_merged;
    logic [31:0]       cur_word;

    cfgspace_decode #(
        .ADDR_W     (ADDR_W),
        .ALIAS_BASE (ALIAS_BASE)
    ) i_decode (
        .acc_is_cfg (acc_is_cfg),
        .acc_addr   (acc_addr),
        .kind       (acc_kind),
        .word_idx   (word_idx)
    );

    assign hit    = (acc_kind != ACC_NONE);
    assign wr_hit = acc_we && hit;

    // status flags: [0] signaled target abort (bit 27), [1] received target
    // abort (bit 28), [2] received master abort (bit 29)
    assign flag_clr = (wr_hit && word_idx == W_CMDSTA && acc_be[3])
                    ? acc_wdata[29:27] : '0;

    cfgspace_w1c #(.N(NFLAG)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  ({evt_rcv_mabort, evt_rcv_tabort, evt_sig_tabort}),
        .clr_mask (flag_clr),
        .flags    (flag_q)
    );

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WIN; gw++) begin : g_win
            localparam logic [WORD_W-1:0] W_RNG = W_WIN0 + WORD_W'(2 * gw);
            localparam logic [WORD_W-1:0] W_CTL = W_WIN0 + WORD_W'(2 * gw + 1);
            cfgspace_window i_win (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_range (wr_hit && word_idx == W_RNG),
                .we_ctrl  (wr_hit && word_idx == W_CTL),
                .be       (acc_be),
                .wdata    (acc_wdata),
                .start_q  (win_start[16*gw +: 16]),
                .end_q    (win_end[16*gw +: 16]),
                .offset_q (win_offset[16*gw +: 16]),
                .en_q     (win_en[gw])
            );
        end
    endgenerate

    // read mux
    always_comb begin
        cur_word = '0;
        if (hit) begin
            unique case (word_idx)
                W_IDENT:  cur_word = {ID_DEVICE, ID_VENDOR};
                W_CMDSTA: cur_word = {2'b00, flag_q, 2'b01, 9'h000, 13'h0000, cmd_q};
                W_CLASS:  cur_word = {ID_CLASS, ID_REV};
                W_IOBAR:  cur_word = {iobase_q, 16'h0001};
                W_MEMBAR: cur_word = {membase_q, 16'h0000};
                W_INTLN:  cur_word = {16'h0000, ID_IPIN, iline_q};
                W_ICTL:   cur_word = {28'h0, ien_q, irq_level};
                default:  cur_word = '0;
            endcase
            for (int n = 0; n < NUM_WIN; n++) begin
                if (word_idx == W_WIN0 + WORD_W'(2 * n)) begin
                    cur_word = {win_end[16*n +: 16], win_start[16*n +: 16]};
                end
                if (word_idx == W_WIN0 + WORD_W'(2 * n + 1)) begin
                    cur_word = {15'h0, win_en[n], win_offset[16*n +: 16]};
                end
            end
        end
    end

    assign acc_rdata = cur_word;
    assign wr_merged = be_merge(cur_word, acc_wdata, acc_be);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            iobase_q  <= '0;
            membase_q <= '0;
            iline_q   <= '0;
            ien_q     <= 1'b0;
        end else if (wr_hit) begin
            unique case (word_idx)
                W_CMDSTA: cmd_q     <= wr_merged[2:0];
                W_IOBAR:  iobase_q  <= wr_merged[31:16];
                W_MEMBAR: membase_q <= wr_merged[31:16];
                W_INTLN:  iline_q   <= wr_merged[7:0];
                W_ICTL:   ien_q     <= wr_merged[3];
                default:  ;
            endcase
        end
    end

    assign io_space_en   = cmd_q[0];
    assign mem_space_en  = cmd_q[1];
    assign bus_master_en = cmd_q[2];
    assign io_base       = iobase_q;
    assign mem_base      = membase_q;
    assign irq_req       = ien_q && (irq_level != 3'd0);

endmodule

// File: rtl/cfgspace_regfile_chk.sv
module cfgspace_regfile_chk
    import cfgspace_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_we,
    input logic [3:0]            acc_be,
    input logic [31:0]           acc_wdata,
    input logic [31:0]           acc_rdata,
    input logic                  evt_sig_tabort,
    input logic [2:0]            irq_level,
    input logic                  irq_req,
    input logic                  io_space_en,
    input logic                  mem_space_en,
    input logic                  bus_master_en,
    input logic [16*NUM_WIN-1:0] win_start,
    input logic [16*NUM_WIN-1:0] win_end,
    input acc_kind_e             acc_kind,
    input logic [WORD_W-1:0]     word_idx,
    input logic [2:0]            flag_q
);

    a_r9_irq_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != 3'd0));

    a_r9_irq_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_kind != ACC_NONE && word_idx == W_ICTL && acc_be[0] && acc_wdata[3])
        |=> (irq_level == 3'd0 || irq_req));

    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |=> $stable({io_space_en, mem_space_en, bus_master_en}));

    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sig_tabort |=> flag_q[0]);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && !acc_we) |=> flag_q[1]);

    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_NONE) |-> (acc_rdata == 32'h0));

    a_r5_iobar_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_NONE && word_idx == W_IOBAR) |-> (acc_rdata[15:0] == 16'h0001));

    a_r8_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |=> ($stable(win_start) && $stable(win_end)));

endmodule

bind cfgspace_regfile cfgspace_regfile_chk #(.NUM_WIN(NUM_WIN)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_we         (acc_we),
    .acc_be         (acc_be),
    .acc_wdata      (acc_wdata),
    .acc_rdata      (acc_rdata),
    .evt_sig_tabort (evt_sig_tabort),
    .irq_level      (irq_level),
    .irq_req        (irq_req),
    .io_space_en    (io_space_en),
    .mem_space_en   (mem_space_en),
    .bus_master_en  (bus_master_en),
    .win_start      (win_start),
    .win_end        (win_end),
    .acc_kind       (acc_kind),
    .word_idx       (word_idx),
    .flag_q         (flag_q)
);

// File: tb/test_cfgspace_regfile.sv
module test_cfgspace_regfile;

    localparam int NUM_WIN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_is_cfg = 1'b1;
    logic [15:0] acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_we = 1'b0;
    logic [31:0] acc_rdata;
    logic        evt_sig_tabort = 1'b0;
    logic        evt_rcv_tabort = 1'b0;
    logic        evt_rcv_mabort = 1'b0;
    logic [2:0]  irq_level = '0;
    logic        io_space_en, mem_space_en, bus_master_en, irq_req;
    logic [15:0] io_base, mem_base;
    logic [NUM_WIN-1:0]    win_en;
    logic [16*NUM_WIN-1:0] win_start, win_end, win_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgspace_regfile #(.NUM_WIN(NUM_WIN)) i_cfgspace_regfile (
        .clk(clk), .rst_n(rst_n), .acc_is_cfg(acc_is_cfg), .acc_addr(acc_addr),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_we(acc_we), .acc_rdata(acc_rdata),
        .evt_sig_tabort(evt_sig_tabort), .evt_rcv_tabort(evt_rcv_tabort),
        .evt_rcv_mabort(evt_rcv_mabort), .irq_level(irq_level),
        .io_space_en(io_space_en), .mem_space_en(mem_space_en),
        .bus_master_en(bus_master_en), .io_base(io_base), .mem_base(mem_base),
        .win_en(win_en), .win_start(win_start), .win_end(win_end),
        .win_offset(win_offset), .irq_req(irq_req)
    );

    typedef struct packed {
        logic        wr;
        logic        cfg;
        logic [15:0] addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b0, 1'b1, 16'h0000, 4'h0, 32'h0,          32'h48001057, 8'd1 },  // R1 ids
        '{1'b0, 1'b0, 16'hF800, 4'h0, 32'h0,          32'h48001057, 8'd11},  // R11 alias read
        '{1'b0, 1'b1, 16'h0008, 4'h0, 32'h0,          32'h06800001, 8'd1 },  // R1 class/rev
        '{1'b1, 1'b1, 16'h000C, 4'hF, 32'hFFFFFFFF,   32'h00000000, 8'd2 },  // R2 fixed zero
        '{1'b1, 1'b1, 16'h003C, 4'hF, 32'hFFFFFFFF,   32'h000001FF, 8'd7 },  // R7 line, pin kept
        '{1'b1, 1'b1, 16'h0010, 4'hF, 32'hFFFFFFFF,   32'hFFFF0001, 8'd5 },  // R5
        '{1'b1, 1'b0, 16'hF814, 4'hF, 32'hABCDFFFF,   32'hABCD0000, 8'd6 },  // R6 via alias
        '{1'b1, 1'b1, 16'h0010, 4'h8, 32'h12345678,   32'h12FF0001, 8'd12},  // R12 one lane
        '{1'b1, 1'b1, 16'h0004, 4'h1, 32'h00000007,   32'h02000007, 8'd3 },  // R3 set cmd
        '{1'b1, 1'b1, 16'h0004, 4'hF, 32'h00000000,   32'h02000000, 8'd3 },  // R3 clear cmd
        '{1'b1, 1'b1, 16'h0040, 4'hF, 32'h20001000,   32'h20001000, 8'd8 },  // R8 win0 range
        '{1'b1, 1'b1, 16'h0044, 4'hF, 32'hFFFF0010,   32'h00010010, 8'd8 },  // R8 win0 ctl
        '{1'b1, 1'b0, 16'hF848, 4'hF, 32'h40003000,   32'h40003000, 8'd11},  // R11 win1 range
        '{1'b1, 1'b1, 16'h004C, 4'h4, 32'h00FFFFFF,   32'h00010000, 8'd12},  // R12 win1 enable only
        '{1'b1, 1'b1, 16'h0050, 4'hF, 32'h000000FF,   32'h00000008, 8'd9 },  // R9 enable
        '{1'b1, 1'b1, 16'h0050, 4'hF, 32'h00000000,   32'h00000000, 8'd9 },  // R9 disable
        '{1'b1, 1'b1, 16'h0080, 4'hF, 32'hFFFFFFFF,   32'h00000000, 8'd10},  // R10 reserved
        '{1'b1, 1'b0, 16'h1010, 4'hF, 32'h00000000,   32'h00000000, 8'd11},  // R11 outside alias
        '{1'b0, 1'b1, 16'h0010, 4'h0, 32'h0,          32'h12FF0001, 8'd11},  // R11 untouched
        '{1'b1, 1'b1, 16'h0054, 4'hF, 32'hFFFFFFFF,   32'h00000000, 8'd10}   // R10 reserved
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic cfg, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] d);
        @(negedge clk);
        acc_is_cfg = cfg; acc_addr = a; acc_be = be; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic do_rd(input logic cfg, input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_is_cfg = cfg; acc_addr = a; acc_we = 1'b0;
        #1;
        d = acc_rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R3 cmd reset", {29'h0, bus_master_en, mem_space_en, io_space_en}, 32'h0);
        do_rd(1'b1, 16'h0010, r); check("R5 iobar reset", r, 32'h00000001);
        do_rd(1'b1, 16'h0014, r); check("R6 membar reset", r, 32'h0);
        do_rd(1'b1, 16'h0004, r); check("R4 status reset", r, 32'h02000000);
        do_rd(1'b1, 16'h003C, r); check("R7 line reset", r, 32'h00000100);
        check("R8 win reset", {30'h0, win_en}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) do_wr(VEC[i].cfg, VEC[i].addr, VEC[i].be, VEC[i].wd);
            do_rd(VEC[i].cfg, VEC[i].addr, r);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
        end

        // outputs after table
        check("R5 io_base", {16'h0, io_base}, 32'h000012FF);
        check("R6 mem_base", {16'h0, mem_base}, 32'h0000ABCD);
        check("R8 win_start", win_start, 32'h30001000);
        check("R8 win_end", win_end, 32'h40002000);
        check("R8 win_offset", win_offset, 32'h00000010);
        check("R8 win_en", {30'h0, win_en}, 32'h3);

        // R3 command outputs
        do_wr(1'b1, 16'h0004, 4'h1, 32'h00000005);
        check("R3 cmd out", {29'h0, bus_master_en, mem_space_en, io_space_en}, 32'h5);
        do_wr(1'b1, 16'h0004, 4'h1, 32'h00000000);

        // R4 abort flags
        @(negedge clk); evt_sig_tabort = 1'b1;
        @(negedge clk); evt_sig_tabort = 1'b0;
        do_rd(1'b1, 16'h0004, r); check("R4 sig abort set", r, 32'h0A000000);
        do_wr(1'b1, 16'h0004, 4'hF, 32'h00000000);
        do_rd(1'b1, 16'h0004, r); check("R4 write zero keeps", r, 32'h0A000000);
        do_wr(1'b1, 16'h0004, 4'hF, 32'h08000000);
        do_rd(1'b1, 16'h0004, r); check("R4 write one clears", r, 32'h02000000);
        @(negedge clk); evt_sig_tabort = 1'b1; evt_rcv_tabort = 1'b1; evt_rcv_mabort = 1'b1;
        @(negedge clk); evt_sig_tabort = 1'b0; evt_rcv_tabort = 1'b0; evt_rcv_mabort = 1'b0;
        do_rd(1'b1, 16'h0004, r); check("R4 all set", r, 32'h3A000000);
        do_wr(1'b1, 16'h0004, 4'hF, 32'h10000000);
        do_rd(1'b1, 16'h0004, r); check("R4 clear one", r, 32'h2A000000);
        do_wr(1'b1, 16'h0004, 4'h7, 32'h38000000);
        do_rd(1'b1, 16'h0004, r); check("R12 clear needs lane", r, 32'h2A000000);
        @(negedge clk);
        acc_is_cfg = 1'b1; acc_addr = 16'h0004; acc_be = 4'hF;
        acc_wdata = 32'h20000000; acc_we = 1'b1; evt_rcv_mabort = 1'b1;
        @(negedge clk); acc_we = 1'b0; evt_rcv_mabort = 1'b0;
        do_rd(1'b1, 16'h0004, r); check("R4 event beats clear", r, 32'h2A000000);

        // R9 interrupt gating
        do_wr(1'b1, 16'h0050, 4'h1, 32'h00000008);
        check("R9 no level no irq", {31'h0, irq_req}, 32'h0);
        @(negedge clk); irq_level = 3'd5; #1;
        check("R9 irq asserted", {31'h0, irq_req}, 32'h1);
        do_rd(1'b0, 16'hF850, r); check("R9 level readback", r, 32'h0000000D);
        do_wr(1'b1, 16'h0050, 4'h1, 32'h00000000);
        #1; check("R9 disabled", {31'h0, irq_req}, 32'h0);
        irq_level = 3'd0;

        // R1 ids survive writes
        do_wr(1'b1, 16'h0000, 4'hF, 32'h0);
        do_rd(1'b1, 16'h0000, r); check("R1 id write ignored", r, 32'h48001057);

        // reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_rd(1'b1, 16'h0040, r); check("R8 window after reset", r, 32'h0);
        do_rd(1'b1, 16'h0010, r); check("R5 iobar after reset", r, 32'h00000001);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule